// File: doc/BRIEF.md
# Reconfigurable Multiprecision Multiplier Array

This block is an unsigned multiplier datapath built from a fixed pool of nine 8x8 multiplier cells. A two-bit precision code reconfigures the pool. It can run as nine independent 8x8 multipliers, as up to three independent 16x16 multipliers, or as one 32x32 multiplier. The operand and product buses are sized for the narrowest mode, which has the most lanes. Each lane of a mode reads a fixed slice of the operand buses and writes a fixed, double-width slice of the product bus.

Each 16x16 product uses three cells in a three-multiplication split: high half times high half, low half times low half, and the product of the two half-sums. Each half-sum is 9 bits wide. Only its low 8 bits pass through a cell, and the carry-out bits are added back as shifted corrections, so every cell stays 8x8. The 32x32 product applies the same split one level higher, across the three 16x16 groups.

Per-lane enables force the operands of an unused lane to zero, so that its cells see no switching activity and its product slice reads zero. The precision code, the enables and the operands are sampled together. The result appears on the registered output one clock later.

Top module: `mp_mul_array`

## Requirements
- R1: While `rst` is high at a rising clock edge, `prod` is cleared to all zeros on that edge.
- R2: `prod` changes only on a rising clock edge. It reflects the `mode`, `lane_en`, `op_a` and `op_b` values sampled at that edge, which gives one cycle of latency.
- R3: With `mode` = 0 (byte mode), lane k (k = 0..8) produces the unsigned product `op_a[8k+7:8k] * op_b[8k+7:8k]` on `prod[16k+15:16k]`.
- R4: With `mode` = 1 (halfword mode), lane k (k = 0..2) produces the unsigned product `op_a[16k+15:16k] * op_b[16k+15:16k]` on `prod[32k+31:32k]`, and `prod[143:96]` is zero.
- R5: With `mode` = 2 (word mode), `prod[63:0]` equals the unsigned product `op_a[31:0] * op_b[31:0]`, and `prod[143:64]` is zero.
- R6: With `mode` = 3 (reserved), all of `prod` is zero, whatever the operands and enables are.
- R7: When `lane_en[k]` is low, lane k of the current mode yields a zero product slice. Enable bits whose index is at or above the lane count of the mode have no effect (bits 3..8 in halfword mode, bits 1..8 in word mode).
- R8: Products are exact for all-ones operands in every mode. In this case every half-sum carries out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Precision code: 0 byte, 1 halfword, 2 word, 3 reserved |
| lane_en | input | 9 | Per-lane enable, bit k gates lane k of the current mode |
| op_a | input | 72 | Multiplicand bus, sliced per lane |
| op_b | input | 72 | Multiplier bus, sliced per lane |
| prod | output | 144 | Registered product bus, packed per lane |

## Verification
The clocked assertions assume that `mode`, `lane_en` and both operand buses hold known, stable values across each rising edge. They also assume the block leaves reset before any result is examined. For this reason they compare each product slice against the inputs of the previous cycle. The stimulus changes every input only at the falling edge and keeps reset high for several edges at the start. It also visits the reserved code and the out-of-range enable bits on purpose, so that the zeroing properties see traffic. The three-cell split check inside each group applies only when that group is combined. It therefore relies on the router keeping the split flag set in byte mode.

// File: rtl/mp_pkg.sv
package mp_pkg;

    localparam int CELL_W      = 8;
    localparam int GROUP_CELLS = 3;
    localparam int NUM_GROUPS  = 3;
    localparam int NUM_CELLS   = GROUP_CELLS * NUM_GROUPS;
    localparam int HALF_W      = 2 * CELL_W;
    localparam int WORD_W      = 4 * CELL_W;
    localparam int OP_W        = NUM_CELLS * CELL_W;
    localparam int PROD_W      = 2 * OP_W;
    localparam int GRP_IN_W    = GROUP_CELLS * CELL_W;

    typedef enum logic [1:0] {
        MODE_B8  = 2'd0,
        MODE_B16 = 2'd1,
        MODE_B32 = 2'd2,
        MODE_OFF = 2'd3
    } prec_mode_e;

    // Operands delivered to one group of three cells.
    // split = 1: each cell multiplies its own byte pair.
    // split = 0: the group forms one product of x[15:0] and y[15:0].
    typedef struct packed {
        logic                split;
        logic [GRP_IN_W-1:0] x;
        logic [GRP_IN_W-1:0] y;
    } grp_in_t;

    // Carry-outs of the two 16-bit half-sums in word mode.
    typedef struct packed {
        logic ca;
        logic cb;
    } wide_carry_t;

endpackage

// File: rtl/mp_cell8.sv
module mp_cell8 #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    assign p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
endmodule

// File: rtl/mp_route.sv
module mp_route
    import mp_pkg::*;
(
    input  prec_mode_e                   mode,
    input  logic [NUM_CELLS-1:0]         lane_en,
    input  logic [OP_W-1:0]              op_a,
    input  logic [OP_W-1:0]              op_b,
    output grp_in_t [NUM_GROUPS-1:0]     gin,
    output wide_carry_t                  wc
);
    logic [HALF_W:0] wsum_a, wsum_b;

    assign wsum_a = {1'b0, op_a[WORD_W-1:HALF_W]} + {1'b0, op_a[HALF_W-1:0]};
    assign wsum_b = {1'b0, op_b[WORD_W-1:HALF_W]} + {1'b0, op_b[HALF_W-1:0]};

    always_comb begin
        gin = '0;
        wc  = '0;
        case (mode)
            MODE_B8: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    gin[g].split = 1'b1;
                    for (int j = 0; j < GROUP_CELLS; j++) begin
                        if (lane_en[g*GROUP_CELLS + j]) begin
                            gin[g].x[j*CELL_W +: CELL_W] = op_a[(g*GROUP_CELLS + j)*CELL_W +: CELL_W];
                            gin[g].y[j*CELL_W +: CELL_W] = op_b[(g*GROUP_CELLS + j)*CELL_W +: CELL_W];
                        end
                    end
                end
            end
            MODE_B16: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (lane_en[g]) begin
                        gin[g].x[HALF_W-1:0] = op_a[g*HALF_W +: HALF_W];
                        gin[g].y[HALF_W-1:0] = op_b[g*HALF_W +: HALF_W];
                    end
                end
            end
            MODE_B32: begin
                if (lane_en[0]) begin
                    gin[0].x[HALF_W-1:0] = op_a[WORD_W-1:HALF_W];
                    gin[0].y[HALF_W-1:0] = op_b[WORD_W-1:HALF_W];
                    gin[1].x[HALF_W-1:0] = op_a[HALF_W-1:0];
                    gin[1].y[HALF_W-1:0] = op_b[HALF_W-1:0];
                    gin[2].x[HALF_W-1:0] = wsum_a[HALF_W-1:0];
                    gin[2].y[HALF_W-1:0] = wsum_b[HALF_W-1:0];
                    wc.ca = wsum_a[HALF_W];
                    wc.cb = wsum_b[HALF_W];
                end
            end
            default: begin
                gin = '0;
                wc  = '0;
            end
        endcase
    end
endmodule

// File: rtl/mp_kara16.sv
module mp_kara16
    import mp_pkg::*;
(
    input  grp_in_t                             gin,
    output logic [GROUP_CELLS*2*CELL_W-1:0]     cell_p,
    output logic [WORD_W-1:0]                   comb_p
);
    localparam int CW = CELL_W;
    localparam int PW = WORD_W;
    localparam int MW = 2*CW + 2;

    logic [CW:0]     sx, sy;
    logic [CW-1:0]   opx [GROUP_CELLS];
    logic [CW-1:0]   opy [GROUP_CELLS];
    logic [2*CW-1:0] hi, lo, st;
    logic [MW-1:0]   m_full, mid;

    assign sx = {1'b0, gin.x[2*CW-1:CW]} + {1'b0, gin.x[CW-1:0]};
    assign sy = {1'b0, gin.y[2*CW-1:CW]} + {1'b0, gin.y[CW-1:0]};

    always_comb begin
        if (gin.split) begin
            for (int j = 0; j < GROUP_CELLS; j++) begin
                opx[j] = gin.x[j*CW +: CW];
                opy[j] = gin.y[j*CW +: CW];
            end
        end else begin
            opx[0] = gin.x[2*CW-1:CW];
            opy[0] = gin.y[2*CW-1:CW];
            opx[1] = gin.x[CW-1:0];
            opy[1] = gin.y[CW-1:0];
            opx[2] = sx[CW-1:0];
            opy[2] = sy[CW-1:0];
        end
    end

    for (genvar j = 0; j < GROUP_CELLS; j++) begin : g_cell
        mp_cell8 #(.W(CW)) u_cell (
            .a (opx[j]),
            .b (opy[j]),
            .p (cell_p[j*2*CW +: 2*CW])
        );
    end

    assign hi = cell_p[2*CW-1:0];
    assign lo = cell_p[4*CW-1:2*CW];
    assign st = cell_p[6*CW-1:4*CW];

    // Full half-sum product rebuilt from the low-byte product and carry terms.
    always_comb begin
        m_full = MW'(st)
               + (sx[CW] ? MW'({sy[CW-1:0], {CW{1'b0}}}) : '0)
               + (sy[CW] ? MW'({sx[CW-1:0], {CW{1'b0}}}) : '0)
               + ((sx[CW] & sy[CW]) ? (MW'(1) << (2*CW)) : '0);
        mid    = m_full - MW'(hi) - MW'(lo);
        comb_p = (PW'(hi) << (2*CW)) + (PW'(mid) << CW) + PW'(lo);
    end

    // R4
    always_comb begin
        if (!gin.split) begin
            kara_exact_chk: assert (comb_p == PW'(gin.x[2*CW-1:0]) * PW'(gin.y[2*CW-1:0]));
        end
    end
endmodule

// File: rtl/mp_mul_array.sv
module mp_mul_array
    import mp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [8:0]        lane_en,
    input  logic [71:0]       op_a,
    input  logic [71:0]       op_b,
    output logic [143:0]      prod
);
    localparam int HW  = HALF_W;
    localparam int MW2 = 2*HW + 2;
    localparam int P64 = 2*WORD_W;
    localparam int NB8 = 2*CELL_W;

    prec_mode_e                          mode_e;
    grp_in_t [NUM_GROUPS-1:0]            gin;
    wide_carry_t                         wc;
    logic [GROUP_CELLS*2*CELL_W-1:0]     cell_p [NUM_GROUPS];
    logic [WORD_W-1:0]                   comb_p [NUM_GROUPS];
    logic [MW2-1:0]                      wm_full, wmid;
    logic [P64-1:0]                      word_p;
    logic [PROD_W-1:0]                   nxt;

    assign mode_e = prec_mode_e'(mode);

    mp_route u_route (
        .mode    (mode_e),
        .lane_en (lane_en),
        .op_a    (op_a),
        .op_b    (op_b),
        .gin     (gin),
        .wc      (wc)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        mp_kara16 u_grp (
            .gin    (gin[g]),
            .cell_p (cell_p[g]),
            .comb_p (comb_p[g])
        );
    end

    // Word mode: group 0 = high halves, group 1 = low halves,
    // group 2 = low 16 bits of the half-sums, carries corrected here.
    always_comb begin
        wm_full = MW2'(comb_p[2])
                + (wc.ca ? MW2'({gin[2].y[HW-1:0], {HW{1'b0}}}) : '0)
                + (wc.cb ? MW2'({gin[2].x[HW-1:0], {HW{1'b0}}}) : '0)
                + ((wc.ca & wc.cb) ? (MW2'(1) << (2*HW)) : '0);
        wmid    = wm_full - MW2'(comb_p[0]) - MW2'(comb_p[1]);
        word_p  = (P64'(comb_p[0]) << (2*HW)) + (P64'(wmid) << HW) + P64'(comb_p[1]);
    end

    always_comb begin
        nxt = '0;
        case (mode_e)
            MODE_B8: begin
                for (int k = 0; k < NUM_CELLS; k++) begin
                    nxt[k*NB8 +: NB8] = cell_p[k / GROUP_CELLS][(k % GROUP_CELLS)*NB8 +: NB8];
                end
            end
            MODE_B16: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    nxt[g*WORD_W +: WORD_W] = comb_p[g];
                end
            end
            MODE_B32: nxt[P64-1:0] = word_p;
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) prod <= '0;
        else     prod <= nxt;
    end

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |=> (prod == '0));

    // R5
    word_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_B32) |=> (prod[143:64] == '0));

    // R5
    word_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_B32 && lane_en[0]) |=>
        (prod[63:0] == 64'($past(op_a[31:0])) * 64'($past(op_b[31:0]))));

    // R4
    half_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_B16) |=> (prod[143:96] == '0));

    // R3
    byte_top_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_B8 && lane_en[8]) |=>
        (prod[143:128] == 16'($past(op_a[71:64])) * 16'($past(op_b[71:64]))));

    // R7
    lane0_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_B8 && !lane_en[0]) |=> (prod[15:0] == '0));
endmodule

// File: tb/sim_mp_mul_array.sv
module sim_mp_mul_array;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   mode;
    logic [8:0]   lane_en;
    logic [71:0]  op_a, op_b;
    logic [143:0] prod;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    mp_mul_array u0 (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .lane_en (lane_en),
        .op_a    (op_a),
        .op_b    (op_b),
        .prod    (prod)
    );

    function automatic logic [143:0] model(logic [1:0] m, logic [8:0] en,
                                           logic [71:0] a, logic [71:0] b);
        logic [143:0] r;
        r = '0;
        case (m)
            2'd0: for (int k = 0; k < 9; k++)
                      if (en[k]) r[k*16 +: 16] = 16'(a[k*8 +: 8]) * 16'(b[k*8 +: 8]);
            2'd1: for (int k = 0; k < 3; k++)
                      if (en[k]) r[k*32 +: 32] = 32'(a[k*16 +: 16]) * 32'(b[k*16 +: 16]);
            2'd2: if (en[0]) r[63:0] = 64'(a[31:0]) * 64'(b[31:0]);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [71:0] rnd72();
        return 72'({$urandom, $urandom, $urandom});
    endfunction

    task automatic check(string req, logic [143:0] got, logic [143:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic run(string req, logic [1:0] m, logic [8:0] en,
                       logic [71:0] a, logic [71:0] b);
        @(negedge clk);
        mode = m; lane_en = en; op_a = a; op_b = b;
        @(negedge clk);
        check(req, prod, model(m, en, a, b));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; mode = 2'd0; lane_en = '1; op_a = '1; op_b = '1;
        @(negedge clk);
        @(negedge clk);
        check("R1", prod, '0);
        rst = 1'b0;
    endtask

    task automatic t_latency();
        logic [71:0] a1, b1;
        a1 = rnd72(); b1 = rnd72();
        run("R2", 2'd0, '1, a1, b1);
        @(negedge clk);
        mode = 2'd1; lane_en = '1; op_a = rnd72(); op_b = rnd72();
        #(CLK_P/4);
        check("R2", prod, model(2'd0, '1, a1, b1));
        @(negedge clk);
        check("R2", prod, model(2'd1, '1, op_a, op_b));
    endtask

    task automatic t_byte();
        for (int i = 0; i < 20; i++) run("R3", 2'd0, '1, rnd72(), rnd72());
    endtask

    task automatic t_half();
        for (int i = 0; i < 20; i++) run("R4", 2'd1, '1, rnd72(), rnd72());
    endtask

    task automatic t_word();
        for (int i = 0; i < 20; i++) run("R5", 2'd2, '1, rnd72(), rnd72());
        run("R5", 2'd2, 9'h001, 72'h0, 72'hFF_FFFF_FFFF);
    endtask

    task automatic t_reserved();
        run("R3", 2'd0, '1, '1, '1);
        for (int i = 0; i < 5; i++) run("R6", 2'd3, '1, rnd72(), rnd72());
    endtask

    task automatic t_enables();
        for (int i = 0; i < 10; i++) run("R7", 2'd0, 9'($urandom), rnd72(), rnd72());
        run("R7", 2'd1, 9'b111111_010, rnd72(), rnd72());
        run("R7", 2'd1, 9'b000000_101, '1, '1);
        run("R7", 2'd2, 9'b111111_110, '1, '1);
        run("R7", 2'd2, 9'b000000_001, rnd72(), rnd72());
    endtask

    task automatic t_ones();
        run("R8", 2'd0, '1, '1, '1);
        run("R8", 2'd1, '1, '1, '1);
        run("R8", 2'd2, '1, '1, '1);
        run("R8", 2'd1, '1, {72{1'b1}}, 72'h0001_0001_0001_8000_8000);
        run("R8", 2'd2, '1, 72'hFFFF_FFFF, 72'hFFFF_0001);
    endtask

    initial begin
        rst = 1'b1; mode = '0; lane_en = '0; op_a = '0; op_b = '0;
        t_reset();
        t_latency();
        t_byte();
        t_half();
        t_word();
        t_reserved();
        t_enables();
        t_ones();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule